// File: doc/BRIEF.md
# Register-Mapped Serial Console Port

This block is a small serial console peripheral for a system bus. It sends and receives asynchronous characters with 8 data bits, no parity and one stop bit. It sends on one output pin and receives on one input pin. Software reaches it through two word registers. The data register starts a transmission when written and returns the last received character when read. The rate register holds the bit-rate divisor.

Bit timing comes from a tick generator that fires once every `divisor` system clocks. A bit lasts 16 such ticks. For a given clock and bit rate, the divisor is the clock frequency divided by sixteen times the bit rate. At reset the divisor takes the value computed from the `CLK_HZ` and `BAUD` parameters.

There is no receive queue. Each character that arrives replaces the one held before it. Two one-cycle interrupt pulses tell software when a character has arrived and when a transmission has completed. After each write to the data register, software waits for the transmit pulse before writing again.

Top module: `serial_console`

## Requirements
- R1: The transmit pin idles high. After a write to the data register (byte address 0x0), the pin sends a low start bit, then the 8 data bits least significant bit first, then a high stop bit. Each of these bits lasts 16 ticks.
- R2: `tx_irq` is high for exactly one clock cycle, once per character, after the stop bit has been fully sent. It is not high during the stop bit.
- R3: The receiver synchronises `rx_pin` and detects a falling start edge. It samples each data bit at the middle of the bit, least significant bit first. A read of byte address 0x0 returns the received byte in bits [7:0], with zeros above.
- R4: `rx_irq` is high for exactly one clock cycle for each character that is accepted.
- R5: The receiver holds a single byte. A second character that arrives before a read replaces the first.
- R6: If the line is high again at the 8th tick after the start edge, the start edge is treated as a glitch. No byte is stored and no `rx_irq` pulse is raised.
- R7: If the stop bit is sampled low, the character is discarded. The held byte and `rx_irq` are left unchanged.
- R8: After reset, the data register reads 0x00. The rate register (byte address 0x4) reads CLK_HZ/(16*BAUD), which is 27 for the default parameters. The transmit pin is high and both interrupts are low.
- R9: A write to the rate register restarts the tick counter. Reading the register back returns the written value. After the write, one bit lasts 16*divisor clock cycles for both transmit and receive.
- R10: A divisor of 0 behaves exactly like a divisor of 1, giving 16 clock cycles per bit.
- R11: Read data appears on `csr_rdata` in the cycle after a read select. A read of any unmapped address returns 0, and writes to unmapped addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 1 | Register access strobe, one cycle |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | ADDR_W | Byte address: 0x0 data, 0x4 rate |
| csr_wdata | input | DW | Write data |
| csr_rdata | output | DW | Registered read data |
| rx_pin | input | 1 | Serial receive line (asynchronous) |
| tx_pin | output | 1 | Serial transmit line |
| rx_irq | output | 1 | One-cycle pulse when a character is received |
| tx_irq | output | 1 | One-cycle pulse when a transmission is done |

## Verification
Most internal faults in this block appear at the ports within one character time. A wrong bit counter or a wrong shift direction changes the decoded value on the transmit pin, or the value read back from the data register. A wrong oversample count moves the bit edges by whole ticks, which the bench's mid-bit sampling catches at divisor 1 and at divisor 3. Faults in the glitch filter or the stop-bit check show up as a spurious `rx_irq` pulse, or as a changed held byte, right after the disturbed frame. The full loop-back sweep over all 256 byte values exposes faults that depend on particular data bits.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned OVS      = 16;
  localparam int unsigned OVS_W    = $clog2(OVS);
  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned BITCNT_W = $clog2(CHAR_W);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_STOP
  } phase_t;
endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
  assign tick = (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R9
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && lim > 1) |=> !tick);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [CHAR_W-1:0] din,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  phase_t              ph;
  logic [OVS_W-1:0]    sub;
  logic [BITCNT_W-1:0] bitc;
  logic [CHAR_W-1:0]   shreg;

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      sub   <= '0;
      bitc  <= '0;
      shreg <= '0;
      txd   <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == PH_IDLE) begin
        if (start) begin
          shreg <= din;
          txd   <= 1'b0;
          sub   <= '0;
          ph    <= PH_START;
        end
      end else if (tick) begin
        if (sub == OVS_W'(OVS - 1)) begin
          sub <= '0;
          case (ph)
            PH_START: begin
              txd   <= shreg[0];
              shreg <= shreg >> 1;
              bitc  <= '0;
              ph    <= PH_DATA;
            end
            PH_DATA: begin
              if (bitc == BITCNT_W'(CHAR_W - 1)) begin
                txd <= 1'b1;
                ph  <= PH_STOP;
              end else begin
                txd   <= shreg[0];
                shreg <= shreg >> 1;
                bitc  <= bitc + 1'b1;
              end
            end
            default: begin
              ph   <= PH_IDLE;
              done <= 1'b1;
            end
          endcase
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  // R1
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R2
  tx_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  output logic [CHAR_W-1:0] dout,
  output logic              valid
);
  logic                s1, s2, s3;
  phase_t              ph;
  logic [OVS_W-1:0]    sub;
  logic [BITCNT_W-1:0] bitc;
  logic [CHAR_W-1:0]   shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      sub   <= '0;
      bitc  <= '0;
      shreg <= '0;
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (s3 && !s2) begin
            sub <= '0;
            ph  <= PH_START;
          end
        end
        PH_START: begin
          if (tick) begin
            if (sub == OVS_W'(OVS/2 - 1)) begin
              sub  <= '0;
              bitc <= '0;
              ph   <= s2 ? PH_IDLE : PH_DATA;
            end else begin
              sub <= sub + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (tick) begin
            if (sub == OVS_W'(OVS - 1)) begin
              sub   <= '0;
              shreg <= {s2, shreg[CHAR_W-1:1]};
              if (bitc == BITCNT_W'(CHAR_W - 1)) ph <= PH_STOP;
              else bitc <= bitc + 1'b1;
            end else begin
              sub <= sub + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (sub == OVS_W'(OVS - 1)) begin
              sub <= '0;
              ph  <= PH_IDLE;
              if (s2) begin
                dout  <= shreg;
                valid <= 1'b1;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R4
  rx_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R7
  rx_out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (valid || $stable(dout)));
endmodule

// File: rtl/serial_console.sv
module serial_console
  import uart_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_sel,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DW-1:0]     csr_wdata,
  output logic [DW-1:0]     csr_rdata,
  input  logic              rx_pin,
  output logic              tx_pin,
  output logic              rx_irq,
  output logic              tx_irq
);
  localparam int unsigned DIV_RST = CLK_HZ / (OVS * BAUD);
  localparam int unsigned WORD_W  = ADDR_W - 2;

  logic [DIV_W-1:0]  div_q;
  logic [CHAR_W-1:0] rx_hold;
  logic [CHAR_W-1:0] rx_byte;
  logic              rx_valid;
  logic              tick;
  logic              tx_busy;
  logic              hit_data, hit_div;
  logic              wr_data, wr_div, rd;
  logic [DW-1:0]     rd_mux;

  assign hit_data = (csr_addr[ADDR_W-1:2] == WORD_W'(0));
  assign hit_div  = (csr_addr[ADDR_W-1:2] == WORD_W'(1));
  assign wr_data  = csr_sel && csr_we && hit_data && !tx_busy;
  assign wr_div   = csr_sel && csr_we && hit_div;
  assign rd       = csr_sel && !csr_we;

  always_comb begin
    rd_mux = '0;
    if (hit_data)     rd_mux[CHAR_W-1:0] = rx_hold;
    else if (hit_div) rd_mux[DIV_W-1:0]  = div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= DIV_W'(DIV_RST);
      rx_hold   <= '0;
      csr_rdata <= '0;
    end else begin
      if (wr_div)   div_q   <= csr_wdata[DIV_W-1:0];
      if (rx_valid) rx_hold <= rx_byte;
      csr_rdata <= rd ? rd_mux : '0;
    end
  end

  assign rx_irq = rx_valid;

  baud_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .div     (div_q),
    .restart (wr_div),
    .tick    (tick)
  );

  uart_tx_core u_tx (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .start (wr_data),
    .din   (csr_wdata[CHAR_W-1:0]),
    .txd   (tx_pin),
    .busy  (tx_busy),
    .done  (tx_irq)
  );

  uart_rx_core u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .rxd   (rx_pin),
    .dout  (rx_byte),
    .valid (rx_valid)
  );

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(rx_hold));
  // R11
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_sel |=> (csr_rdata == '0));
endmodule

// File: tb/serial_console_test.sv
module serial_console_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csr_sel = 1'b0;
  logic          csr_we = 1'b0;
  logic [3:0]    csr_addr = '0;
  logic [DW-1:0] csr_wdata = '0;
  logic [DW-1:0] csr_rdata;
  logic          rx_drv = 1'b1;
  logic          lb = 1'b0;
  logic          rx_pin;
  logic          tx_pin, rx_irq, tx_irq;

  int n_chk = 0;
  int n_bad = 0;
  int rx_cnt = 0;
  int tx_cnt = 0;
  bit finished = 0;

  assign rx_pin = lb ? tx_pin : rx_drv;

  always #10 clk = ~clk;

  serial_console uut (
    .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  always @(posedge clk) begin
    if (rx_irq) rx_cnt <= rx_cnt + 1;
    if (tx_irq) tx_cnt <= tx_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    csr_sel = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_sel = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    csr_sel = 1'b1; csr_we = 1'b0; csr_addr = a;
    @(negedge clk);
    csr_sel = 1'b0;
    d = csr_rdata;
  endtask

  // Sends a byte and decodes the transmit pin at mid-bit; bitlen in cycles.
  task automatic tx_and_decode(input logic [7:0] v, input int bitlen, input string req);
    logic [7:0] got;
    int t0;
    t0 = tx_cnt;
    got = '0;
    csr_write(4'h0, DW'(v));
    repeat (bitlen/2 - 1) @(negedge clk);
    check(tx_pin == 1'b0, {req, " start bit"}, tx_pin, 0);
    for (int k = 0; k < 8; k++) begin
      repeat (bitlen) @(negedge clk);
      got[k] = tx_pin;
    end
    check(got == v, {req, " data bits"}, got, v);
    repeat (bitlen) @(negedge clk);
    check(tx_pin == 1'b1, {req, " stop bit"}, tx_pin, 1);
    check(tx_cnt == t0, "R2 no tx_irq during stop bit", tx_cnt - t0, 0);
    repeat (bitlen/2 + 4) @(negedge clk);
    check(tx_cnt == t0 + 1, "R2 one tx_irq per char", tx_cnt - t0, 1);
  endtask

  task automatic rx_send(input logic [7:0] v, input logic stopv, input int bitlen);
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (bitlen) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rx_drv = v[k];
      repeat (bitlen) @(negedge clk);
    end
    rx_drv = stopv;
    repeat (bitlen) @(negedge clk);
    rx_drv = 1'b1;
    repeat (2 * bitlen) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    int c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(tx_pin == 1'b1 && !rx_irq && !tx_irq, "R8 pins after reset",
          {tx_pin, rx_irq, tx_irq}, 3'b100);
    csr_read(4'h0, r);
    check(r == 0, "R8 data reset", r, 0);
    csr_read(4'h4, r);
    check(r == 27, "R8 divisor reset", r, 27);
    // R11 unmapped
    csr_write(4'h8, 32'hFFFF);
    csr_read(4'h8, r);
    check(r == 0, "R11 unmapped read", r, 0);
    csr_read(4'h4, r);
    check(r == 27, "R11 unmapped write ignored", r, 27);

    // R9 divisor 1
    csr_write(4'h4, 32'd1);
    csr_read(4'h4, r);
    check(r == 1, "R9 divisor readback", r, 1);

    // R1 / R2 transmit patterns
    tx_and_decode(8'hA5, 16, "R1 A5");
    tx_and_decode(8'h01, 16, "R1 01");
    tx_and_decode(8'h80, 16, "R1 80");
    tx_and_decode(8'h00, 16, "R1 00");
    tx_and_decode(8'hFF, 16, "R1 FF");

    // R3 / R4 receive
    c0 = rx_cnt;
    rx_send(8'h3C, 1'b1, 16);
    check(rx_cnt == c0 + 1, "R4 one rx_irq", rx_cnt - c0, 1);
    csr_read(4'h0, r);
    check(r == 32'h3C, "R3 received byte", r, 32'h3C);

    // R5 overwrite
    c0 = rx_cnt;
    rx_send(8'h11, 1'b1, 16);
    rx_send(8'h22, 1'b1, 16);
    check(rx_cnt == c0 + 2, "R5 two rx_irq", rx_cnt - c0, 2);
    csr_read(4'h0, r);
    check(r == 32'h22, "R5 newest byte kept", r, 32'h22);

    // R6 glitch
    c0 = rx_cnt;
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    check(rx_cnt == c0, "R6 glitch no irq", rx_cnt - c0, 0);
    csr_read(4'h0, r);
    check(r == 32'h22, "R6 glitch data kept", r, 32'h22);

    // R7 bad stop bit
    c0 = rx_cnt;
    rx_send(8'h55, 1'b0, 16);
    check(rx_cnt == c0, "R7 bad stop no irq", rx_cnt - c0, 0);
    csr_read(4'h0, r);
    check(r == 32'h22, "R7 bad stop data kept", r, 32'h22);

    // R10 divisor 0
    csr_write(4'h4, 32'd0);
    csr_read(4'h4, r);
    check(r == 0, "R10 divisor 0 readback", r, 0);
    tx_and_decode(8'h96, 16, "R10 div0");

    // R9 divisor 3
    csr_write(4'h4, 32'd3);
    tx_and_decode(8'h5A, 48, "R9 div3 tx");
    c0 = rx_cnt;
    rx_send(8'hC3, 1'b1, 48);
    check(rx_cnt == c0 + 1, "R9 div3 rx irq", rx_cnt - c0, 1);
    csr_read(4'h0, r);
    check(r == 32'hC3, "R9 div3 rx byte", r, 32'hC3);

    // R3 / R1 loop-back sweep of every byte value at divisor 1
    csr_write(4'h4, 32'd1);
    lb = 1'b1;
    repeat (4) @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      int t0, r0, w;
      t0 = tx_cnt;
      r0 = rx_cnt;
      csr_write(4'h0, DW'(v));
      w = 0;
      while (tx_cnt == t0 && w < 400) begin
        @(negedge clk);
        w++;
      end
      csr_read(4'h0, r);
      check(r == DW'(v) && rx_cnt == r0 + 1, "R3 loop-back byte", r, v);
    end
    lb = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule